// File: doc/BRIEF.md
# Entropy Source Health Monitor

This block sits beside a raw entropy source and watches the serial bit stream that the source produces. Each bit arrives with a one-cycle valid strobe. Two repetition tests run on the stream. The first checks for long runs of one bit value. The second checks for a long chain of the same alternating two-bit pair. Two more fault sources come from outside as single-cycle pulses: an adaptive proportion test, which may fail at startup or while running, and a startup conditioning sanity check.

Any fault raises two outputs. The first is a current seed-error status, which stays high until software restarts the tests through a clear input. The second is a sticky interrupt flag. Software clears this flag with its own strobe, and it stays set across a restart of the tests. The bit input is a valid-only stream with no back-pressure. The monitor has no ready output and takes one bit on every cycle where `bit_valid` is high. Cycles where `bit_valid` is low carry no data.

Top module: `noise_health_monitor`

## Requirements
- R1: After reset, `seed_err_now` and `seed_err_irq` are both 0.
- R2: When 25 or more consecutive valid bits have the same value (all 0 or all 1), the single-bit test fails and both outputs are 1 after the clock edge that took the 25th bit. A run of 24 does not fail.
- R3: Valid bits form non-overlapping pairs (first bit, second bit), starting from the first valid bit after reset or a restart. When the pair 01, or the pair 10, occurs 33 times in a row, the pair test fails on the 33rd pair. A chain of 32 does not fail.
- R4: Any pair that differs from the previous pair restarts the pair count. This includes 00, 11 and the other alternating pair. The stream 0110 0110 … never fails.
- R5: Cycles with `bit_valid` low change no test state. Such cycles do not break a run.
- R6: A one-cycle pulse on `apt_fail` sets both outputs.
- R7: A one-cycle pulse on `cond_fail` sets both outputs.
- R8: `seed_err_now` stays 1 until `err_clear` is pulsed. That pulse clears it, resets both tests' counters and pair alignment, and discards any bit offered in the same cycle.
- R9: `seed_err_irq` stays 1 across `err_clear` and returns to 0 only on an `irq_clear` pulse.
- R10: A fault in the same cycle as `irq_clear` or `err_clear` wins: the output it sets is 1 after that edge.
- R11: Run and pair counters saturate and never wrap. A run still reports a fault on every further identical bit, for example after 40 identical bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Raw bit strobe |
| bit_in | input | 1 | Raw noise bit |
| apt_fail | input | 1 | Adaptive proportion test fail pulse |
| cond_fail | input | 1 | Conditioning sanity check fail pulse |
| err_clear | input | 1 | Restart tests and clear current status |
| irq_clear | input | 1 | Clear the sticky interrupt flag |
| seed_err_now | output | 1 | Current seed error status |
| seed_err_irq | output | 1 | Sticky seed error interrupt flag |

## Verification
The run test is driven with runs of exactly 24 and exactly 25 bits of each value. Those lengths show whether the limit sits at the right count. The pair test gets 32 and 33 repeats of 01, and of 10 after a one-bit offset. It also gets the 0110 stream, which repeats every four bits but never repeats a pair. That stream separates correct pair reset from a counter that only looks at bit changes. Runs broken by idle cycles, 40-bit runs, and faults that coincide with a clear check the strobe gating, the saturation and the priorities.

// File: rtl/nhm_pkg.sv
package nhm_pkg;
  localparam int FLT_RUN  = 0;
  localparam int FLT_PAIR = 1;
  localparam int FLT_APT  = 2;
  localparam int FLT_COND = 3;
  localparam int N_FLT    = 4;
endpackage

// File: rtl/nhm_run_test.sv
module nhm_run_test #(
  parameter int RUN_LIMIT = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic vld,
  input  logic din,
  output logic fail
);
  localparam int CW = $clog2(RUN_LIMIT + 2);
  localparam logic [CW-1:0] CMAX = CW'(RUN_LIMIT + 1);

  logic          last_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          same;

  assign same = (cnt_q != '0) && (din == last_q);

  always_comb begin
    cnt_d = cnt_q;
    if (vld) begin
      if (!same)              cnt_d = CW'(1);
      else if (cnt_q != CMAX) cnt_d = cnt_q + CW'(1);
    end
  end

  assign fail = vld && !clr && same && (cnt_q >= CW'(RUN_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (vld) begin
      cnt_q  <= cnt_d;
      last_q <= din;
    end
  end

  assert_cnt_saturates_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CMAX);
  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/nhm_pair_test.sv
module nhm_pair_test #(
  parameter int PAIR_LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic vld,
  input  logic din,
  output logic fail
);
  localparam int CW = $clog2(PAIR_LIMIT + 2);
  localparam logic [CW-1:0] CMAX = CW'(PAIR_LIMIT + 1);

  logic          half_q;
  logic          first_q;
  logic [1:0]    prev_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    pair;
  logic          alt, repeat_pair, pair_done;

  assign pair        = {first_q, din};
  assign alt         = first_q ^ din;
  assign pair_done   = vld && half_q;
  assign repeat_pair = (cnt_q != '0) && (pair == prev_q);

  always_comb begin
    cnt_d = cnt_q;
    if (pair_done) begin
      if (!alt)               cnt_d = '0;
      else if (!repeat_pair)  cnt_d = CW'(1);
      else if (cnt_q != CMAX) cnt_d = cnt_q + CW'(1);
    end
  end

  assign fail = pair_done && !clr && alt && repeat_pair &&
                (cnt_q >= CW'(PAIR_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      first_q <= 1'b0;
      prev_q  <= 2'b00;
      cnt_q   <= '0;
    end else if (clr) begin
      half_q  <= 1'b0;
      first_q <= 1'b0;
      prev_q  <= 2'b00;
      cnt_q   <= '0;
    end else if (vld) begin
      half_q <= !half_q;
      if (!half_q) first_q <= din;
      else         prev_q  <= pair;
      cnt_q <= cnt_d;
    end
  end

  assert_flat_pair_resets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_done && !alt) |=> (cnt_q == '0));
  assert_pair_cnt_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CMAX);
  assert_half_toggles_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !clr) |=> (half_q != $past(half_q)));
endmodule

// File: rtl/nhm_status.sv
module nhm_status
  import nhm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_FLT-1:0] faults,
  input  logic             err_clear,
  input  logic             irq_clear,
  output logic             now_q,
  output logic             irq_q
);
  logic any_fault;
  assign any_fault = |faults;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      now_q <= (now_q && !err_clear) || any_fault;
      irq_q <= (irq_q && !irq_clear) || any_fault;
    end
  end

  assert_fault_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    any_fault |=> (now_q && irq_q));
  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clear) |=> irq_q);
  assert_now_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (now_q && !err_clear) |=> now_q);
  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clear && !any_fault) |=> !now_q);
endmodule

// File: rtl/noise_health_monitor.sv
module noise_health_monitor
  import nhm_pkg::*;
#(
  parameter int RUN_LIMIT  = 24,
  parameter int PAIR_LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_in,
  input  logic apt_fail,
  input  logic cond_fail,
  input  logic err_clear,
  input  logic irq_clear,
  output logic seed_err_now,
  output logic seed_err_irq
);
  logic [N_FLT-1:0] faults;

  nhm_run_test #(.RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(err_clear), .vld(bit_valid),
    .din(bit_in), .fail(faults[FLT_RUN])
  );

  nhm_pair_test #(.PAIR_LIMIT(PAIR_LIMIT)) u_pair (
    .clk(clk), .rst_n(rst_n), .clr(err_clear), .vld(bit_valid),
    .din(bit_in), .fail(faults[FLT_PAIR])
  );

  assign faults[FLT_APT]  = apt_fail;
  assign faults[FLT_COND] = cond_fail;

  nhm_status u_status (
    .clk(clk), .rst_n(rst_n), .faults(faults), .err_clear(err_clear),
    .irq_clear(irq_clear), .now_q(seed_err_now), .irq_q(seed_err_irq)
  );

  assert_ext_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (apt_fail || cond_fail) |=> seed_err_now);
endmodule

// File: tb/test_noise_health_monitor.sv
module test_noise_health_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0, bit_in = 1'b0, apt_fail = 1'b0, cond_fail = 1'b0;
  logic err_clear = 1'b0, irq_clear = 1'b0;
  logic seed_err_now, seed_err_irq;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  noise_health_monitor i_noise_health_monitor (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .apt_fail(apt_fail), .cond_fail(cond_fail), .err_clear(err_clear),
    .irq_clear(irq_clear), .seed_err_now(seed_err_now),
    .seed_err_irq(seed_err_irq)
  );

  task automatic check(string req, logic act_now, logic exp_now,
                       logic act_irq, logic exp_irq);
    checks++;
    if (act_now !== exp_now || act_irq !== exp_irq) begin
      failures++;
      $display("FAIL %s: now=%b irq=%b expected now=%b irq=%b",
               req, act_now, act_irq, exp_now, exp_irq);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); bit_valid = 1'b1; bit_in = b;
    @(negedge clk); bit_valid = 1'b0;
  endtask

  task automatic send_run(logic b, int n);
    for (int i = 0; i < n; i++) send_bit(b);
  endtask

  task automatic send_pairs(logic [1:0] p, int n);
    for (int i = 0; i < n; i++) begin send_bit(p[1]); send_bit(p[0]); end
  endtask

  task automatic restart_all();
    @(negedge clk); err_clear = 1'b1; irq_clear = 1'b1;
    @(negedge clk); err_clear = 1'b0; irq_clear = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset", seed_err_now, 1'b0, seed_err_irq, 1'b0);
  endtask

  task automatic t_runs();
    for (int v = 0; v < 2; v++) begin
      restart_all();
      send_run(v[0], 24);
      check("R2 run of 24", seed_err_now, 1'b0, seed_err_irq, 1'b0);
      send_bit(v[0]);
      check("R2 run of 25", seed_err_now, 1'b1, seed_err_irq, 1'b1);
    end
  endtask

  task automatic t_pairs();
    restart_all();
    send_pairs(2'b01, 32);
    check("R3 32 pairs 01", seed_err_now, 1'b0, seed_err_irq, 1'b0);
    send_pairs(2'b01, 1);
    check("R3 33 pairs 01", seed_err_now, 1'b1, seed_err_irq, 1'b1);
    restart_all();
    send_bit(1'b1);
    send_pairs(2'b01, 32);
    check("R3 offset 32 pairs 10", seed_err_now, 1'b0, seed_err_irq, 1'b0);
    send_bit(1'b0);
    send_bit(1'b1);
    check("R3 offset 33 pairs 10", seed_err_now, 1'b1, seed_err_irq, 1'b1);
  endtask

  task automatic t_pair_reset();
    restart_all();
    for (int i = 0; i < 50; i++) begin send_pairs(2'b01, 1); send_pairs(2'b10, 1); end
    check("R4 0110 stream", seed_err_now, 1'b0, seed_err_irq, 1'b0);
    restart_all();
    send_pairs(2'b10, 20); send_pairs(2'b11, 1); send_pairs(2'b10, 20);
    check("R4 flat pair restarts count", seed_err_now, 1'b0, seed_err_irq, 1'b0);
  endtask

  task automatic t_idle();
    restart_all();
    send_run(1'b1, 20);
    repeat (5) begin @(negedge clk); bit_in = 1'b0; end
    send_run(1'b1, 4);
    check("R5 idle gap 24", seed_err_now, 1'b0, seed_err_irq, 1'b0);
    send_bit(1'b1);
    check("R5 idle gap 25", seed_err_now, 1'b1, seed_err_irq, 1'b1);
  endtask

  task automatic t_external();
    restart_all();
    @(negedge clk); apt_fail = 1'b1; @(negedge clk); apt_fail = 1'b0;
    check("R6 apt pulse", seed_err_now, 1'b1, seed_err_irq, 1'b1);
    restart_all();
    @(negedge clk); cond_fail = 1'b1; @(negedge clk); cond_fail = 1'b0;
    check("R7 cond pulse", seed_err_now, 1'b1, seed_err_irq, 1'b1);
  endtask

  task automatic t_clear();
    restart_all();
    @(negedge clk); apt_fail = 1'b1; @(negedge clk); apt_fail = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 status holds", seed_err_now, 1'b1, seed_err_irq, 1'b1);
    send_run(1'b0, 10);
    @(negedge clk); err_clear = 1'b1; bit_valid = 1'b1; bit_in = 1'b0;
    @(negedge clk); err_clear = 1'b0; bit_valid = 1'b0;
    check("R8 R9 err_clear keeps irq", seed_err_now, 1'b0, seed_err_irq, 1'b1);
    send_run(1'b0, 24);
    check("R8 counters restarted", seed_err_now, 1'b0, seed_err_irq, 1'b1);
    @(negedge clk); irq_clear = 1'b1; @(negedge clk); irq_clear = 1'b0;
    check("R9 irq_clear", seed_err_now, 1'b0, seed_err_irq, 1'b0);
  endtask

  task automatic t_priority();
    restart_all();
    @(negedge clk); apt_fail = 1'b1;
    @(negedge clk); apt_fail = 1'b0;
    @(negedge clk); irq_clear = 1'b1; err_clear = 1'b1; cond_fail = 1'b1;
    @(negedge clk); irq_clear = 1'b0; err_clear = 1'b0; cond_fail = 1'b0;
    check("R10 fault beats clears", seed_err_now, 1'b1, seed_err_irq, 1'b1);
  endtask

  task automatic t_saturate();
    restart_all();
    send_run(1'b1, 40);
    @(negedge clk); irq_clear = 1'b1; err_clear = 1'b0;
    @(negedge clk); irq_clear = 1'b0;
    check("R11 irq cleared mid-run", seed_err_now, 1'b1, seed_err_irq, 1'b0);
    send_bit(1'b1);
    check("R11 run 41 still fails", seed_err_now, 1'b1, seed_err_irq, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_runs();
    t_pairs();
    t_pair_reset();
    t_idle();
    t_external();
    t_clear();
    t_priority();
    t_saturate();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule